// File: doc/BRIEF.md
# Configurable Serial Character Framer

This block turns one data word per handshake into an asynchronous serial frame on a single output line. The frame begins with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then one or two high stop bits. The line rests high between frames.

The character length comes from a 3-bit size code. The parity bit is present only when parity framing is switched on, and its sense can be even or odd. The stop-bit count is also selectable. An external divider supplies the bit rate as a one-cycle tick per bit period. Every bit of a frame starts on a tick and lasts exactly one tick period.

A one-word holding stage accepts the next character while the current frame is still on the line, so frames can follow each other with no gap. The configuration inputs are read at the moment a frame is loaded. The `idle` output tells the surrounding logic when the transmitter can be shut down without cutting a character short.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `busy` is 0, `idle` is 1 and `in_ready` is 1.
- R2: A frame starts on a `baud_tick` edge. The first bit is a 0 start bit, and the data bits follow starting with `in_data[0]`. Each bit is held for exactly one tick period.
- R3: Size code 0 sends 8 data bits, code 1 sends 9, and codes 5, 6 and 7 send 5, 6 and 7 data bits. Data bits above the selected length are not sent.
- R4: Size codes 2, 3 and 4 are reserved and send 8 data bits.
- R5: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd` = 0 the data bits plus the parity bit hold an even number of ones. With `cfg_par_odd` = 1 they hold an odd number of ones. Only the transmitted data bits count.
- R6: When `cfg_par_en` is 0, the stop bits follow the last data bit directly.
- R7: `cfg_two_stop` = 0 sends one high stop bit and 1 sends two high stop bits.
- R8: The configuration is taken when the frame is loaded. Changing any `cfg_*` input afterwards leaves the frame in progress unchanged.
- R9: A word handed over while a frame is in flight is held. While it waits, `in_ready` is 0. `idle` is 1 only when no frame is on the line and no word is waiting, and it is 0 in the cycle after any accepted handshake.
- R10: If a word is waiting when the last stop bit of a frame ends, its start bit begins on that same tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | DATA_W (9) | Character to send, LSB first |
| in_valid | input | 1 | Offered word is valid |
| in_ready | output | 1 | Holding stage can take a word |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_size | input | 3 | Character size code |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | 0 even, 1 odd parity |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is on the line |
| idle | output | 1 | No frame in flight and no word waiting |

## Verification
The bench builds the block with the default data width of 9, so the frame register is 13 bits wide. That lets the 9-bit size code, the longest frame (9 data bits, parity and two stop bits) and every shorter mix be driven and compared bit by bit. The bit tick runs every fourth clock. This leaves idle cycles between ticks in which words can be accepted mid-frame, which makes the no-gap chaining between frames and the mid-frame configuration changes observable.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  typedef struct packed {
    logic [2:0] size;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } uftx_cfg_t;

  // Size code to data-bit count; reserved codes fall back to 8.
  function automatic int size_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 9;
      3'd5:    return 5;
      3'd6:    return 6;
      3'd7:    return 7;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/uftx_rst_sync.sv
module uftx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/uftx_frame_build.sv
module uftx_frame_build
  import uftx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  uftx_cfg_t          cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   len_o
);
  int   nbits;
  logic par;

  always_comb begin
    nbits = size_bits(cfg_i.size);
    if (nbits > DATA_W) nbits = DATA_W;
    frame_o    = '1;
    frame_o[0] = 1'b0;
    par        = cfg_i.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame_o[1+i] = data_i[i];
        par          = par ^ data_i[i];
      end
    end
    if (cfg_i.par_en) frame_o[1+nbits] = par;
    len_o = CNT_W'(2 + nbits + int'(cfg_i.par_en) + int'(cfg_i.two_stop));
  end
endmodule

// File: rtl/uftx_serializer.sv
module uftx_serializer #(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               tick_i,
  input  logic               load_req_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               take_o,
  output logic               tx_o,
  output logic               active_o
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    take_o = 1'b0;
    if (tick_i) begin
      if (act_q && cnt_q > CNT_W'(1)) begin
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_d = cnt_q - 1'b1;
      end else if (load_req_i) begin
        sh_d   = frame_i;
        cnt_d  = len_i;
        act_d  = 1'b1;
        take_o = 1'b1;
      end else begin
        sh_d  = '1;
        cnt_d = '0;
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign tx_o     = act_q ? sh_q[0] : 1'b1;
  assign active_o = act_q;

  // R2: a loaded frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_sn)
    take_o |=> (act_q && !sh_q[0]));
  // R2: the line bit only moves on a tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q && !tick_i) |=> $stable(tx_o));
  // R7: the final bit of every frame is a high stop bit
  a_r7_last_bit_high: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q && cnt_q == CNT_W'(1)) |-> sh_q[0]);
  // R3: frame length stays within 7..FRAME_W bits
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_sn)
    take_o |-> (len_i >= CNT_W'(7) && len_i <= CNT_W'(FRAME_W)));
  // R10: a waiting word starts on the tick that ends the previous frame
  a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick_i && act_q && cnt_q == CNT_W'(1) && load_req_i) |=> (act_q && !tx_o));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              tx_line,
  output logic              busy,
  output logic              idle
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               rst_sn;
  logic               pend_v_q, pend_v_d;
  logic [DATA_W-1:0]  pend_d_q, pend_d_d;
  logic               take;
  logic               active;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  uftx_cfg_t          cfg;

  assign cfg = '{size: cfg_size, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  uftx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  uftx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .data_i  (pend_d_q),
    .cfg_i   (cfg),
    .frame_o (frame),
    .len_o   (len)
  );

  uftx_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ser (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .tick_i     (baud_tick),
    .load_req_i (pend_v_q),
    .frame_i    (frame),
    .len_i      (len),
    .take_o     (take),
    .tx_o       (tx_line),
    .active_o   (active)
  );

  assign in_ready = !pend_v_q;

  always_comb begin
    pend_v_d = pend_v_q;
    pend_d_d = pend_d_q;
    if (take) pend_v_d = 1'b0;
    if (in_valid && in_ready) begin
      pend_v_d = 1'b1;
      pend_d_d = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
    end else begin
      pend_v_q <= pend_v_d;
      pend_d_q <= pend_d_d;
    end
  end

  assign busy = active;
  assign idle = !active && !pend_v_q;

  // R9: an accepted word makes the block non-idle next cycle
  a_r9_accept_not_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_ready) |=> !idle);
  // R1: an idle block keeps the line high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_sn)
    idle |-> tx_line);
  // R9: a waiting word stays until the serializer takes it
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_sn)
    (!in_ready && !take) |=> !in_ready);
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int DATA_W = 9;

  typedef struct packed {
    logic [15:0] bits;
    logic [4:0]  len;
    logic        chk_gap;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             baud_tick = 1'b0;
  logic [2:0]       cfg_size = 3'd0;
  logic             cfg_par_en = 1'b0;
  logic             cfg_par_odd = 1'b0;
  logic             cfg_two_stop = 1'b0;
  logic             tx_line, busy, idle;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   mon_on = 1'b0;
  exp_t exp_q[$];
  int   tick_div = 0;

  always #2.5 clk = ~clk;

  uart_frame_tx #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .baud_tick(baud_tick), .cfg_size(cfg_size),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .tx_line(tx_line), .busy(busy), .idle(idle)
  );

  always @(negedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == 3);
  end

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t build_exp(input logic [8:0] d, input logic [2:0] sz,
                                     input logic pe, input logic po, input logic ts);
    exp_t e;
    int   n, idx;
    logic p;
    case (sz)
      3'd1: n = 9;
      3'd5: n = 5;
      3'd6: n = 6;
      3'd7: n = 7;
      default: n = 8;
    endcase
    e.bits    = '1;
    e.bits[0] = 1'b0;
    p = po;
    for (int i = 0; i < n; i++) begin
      e.bits[1+i] = d[i];
      p = p ^ d[i];
    end
    idx = 1 + n;
    if (pe) begin
      e.bits[idx] = p;
      idx++;
    end
    e.len     = 5'(idx + 1 + int'(ts));
    e.chk_gap = 1'b0;
    return e;
  endfunction

  // Driver: offer one word, push expected frame, hold config until loaded.
  task automatic send(input logic [8:0] d, input logic [2:0] sz,
                      input logic pe, input logic po, input logic ts);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    e = build_exp(d, sz, pe, po, ts);
    e.chk_gap = busy && !baud_tick;
    exp_q.push_back(e);
    in_data = d; cfg_size = sz; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 idle after accept", int'(idle), 0);
    if (e.chk_gap) check("R9 ready low while waiting", int'(in_ready), 0);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R9 idle after drain", int'(idle), 1);
    check("R7 line high after frame", int'(tx_line), 1);
  endtask

  // Monitor: sample the finishing bit in each tick cycle.
  logic [15:0] got;
  int          nb = 0;
  int          gap = 0;
  bit          in_frame = 1'b0;
  always @(negedge clk) begin
    if (mon_on && baud_tick) begin
      if (!in_frame) begin
        if (tx_line == 1'b0) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected frame", 1, 0);
          end else begin
            if (exp_q[0].chk_gap) check("R10 back-to-back gap", gap, 0);
            in_frame = 1'b1;
            got = '1;
            got[0] = 1'b0;
            nb = 1;
          end
        end else begin
          gap++;
        end
      end else begin
        check("R2 busy during frame", int'(busy), 1);
        got[nb] = tx_line;
        nb++;
        if (nb == int'(exp_q[0].len)) begin
          check("R3-R7 frame bits", int'(got & ((16'd1 << nb) - 16'd1)),
                int'(exp_q[0].bits & ((16'd1 << nb) - 16'd1)));
          void'(exp_q.pop_front());
          in_frame = 1'b0;
          gap = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 tx_line", int'(tx_line), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 idle", int'(idle), 1);
    check("R1 in_ready", int'(in_ready), 1);
    mon_on = 1'b1;

    send(9'h0A5, 3'd0, 1'b0, 1'b0, 1'b0); drain();  // R3 8 bits, R6 no parity
    send(9'h1C3, 3'd1, 1'b1, 1'b0, 1'b0); drain();  // R3 9 bits, R5 even
    send(9'h1FF, 3'd5, 1'b1, 1'b1, 1'b1); drain();  // R3 5 bits, R5 odd, R7 two stop
    send(9'h02D, 3'd6, 1'b1, 1'b0, 1'b0); drain();  // R3 6 bits
    send(9'h155, 3'd7, 1'b1, 1'b1, 1'b1); drain();  // R3 7 bits
    send(9'h13C, 3'd2, 1'b1, 1'b0, 1'b0); drain();  // R4 reserved
    send(9'h0F0, 3'd3, 1'b0, 1'b0, 1'b1); drain();  // R4 reserved
    send(9'h181, 3'd4, 1'b1, 1'b1, 1'b0); drain();  // R4 reserved

    // R8: change every config input once the frame is loaded
    send(9'h0C6, 3'd0, 1'b1, 1'b0, 1'b1);
    cfg_size = 3'd5; cfg_par_en = 1'b0; cfg_par_odd = 1'b1; cfg_two_stop = 1'b0;
    drain();

    // R10 / R9: chained frames with a waiting word
    send(9'h011, 3'd0, 1'b0, 1'b0, 1'b0);
    send(9'h1EE, 3'd1, 1'b1, 1'b1, 1'b1);
    send(9'h005, 3'd7, 1'b0, 1'b0, 1'b1);
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule